// File: doc/BRIEF.md
# Event-Driven Sparse Fully Connected Processing Element

This processing element computes one slice of a fully connected layer. It never sees zero activations. Each incoming event carries one non-zero input activation and the address of the input neuron that produced it. The element looks up where that neuron's weights sit in local storage. It then multiplies the activation by every stored weight of the neuron and adds the products into the output accumulators that those weights feed. Up to four weights are applied on each clock cycle. A neuron with more weights keeps the event port stalled until all of its weights have been applied.

Two weight layouts are supported, chosen by a mode input. In the sparse layout, each stored weight carries the global index of the output neuron it feeds. Zero weights are simply not stored. Each element subtracts its own base index from the stored index, and it drops weights that fall outside its slice of 16 outputs. In the dense layout, pruned neurons have already been removed. The k-th weight of a neuron feeds local output k, and the stored index field is ignored. Several elements share a layer by receiving the same event at the same time, each with a different base index. A clear input resets the accumulators between inputs. A read port exposes any accumulator once an inference is complete.

Top module: `sfc_pe`

## Requirements
- R1: After reset, `evt_ready_o` is 1, every accumulator reads 0, and every pointer-table entry has a count of 0.
- R2: An event is accepted on a rising edge where `evt_valid_i` and `evt_ready_o` are both 1. `evt_ready_o` then stays 0 for exactly max(1, ceil(count/4)) cycles, where count is the entry count of the addressed neuron. It then returns to 1, and at that point every update from the event is visible.
- R3: For the input neuron at `evt_addr_i`, the pointer table gives a start address `ptr_start_i` and an entry count `ptr_cnt_i`, both written through the `ptr_en_i` port. The entries used are start, start+1, … up to start+count-1, taken modulo 64. Rewriting a pointer changes which entries a later event uses.
- R4: With `mode_i`=0 (sparse), each entry adds the signed product `evt_val_i`×weight to the local output (index − `base_i`) when that value lies in 0..15. Entries whose index falls outside that range are dropped.
- R5: With `mode_i`=1 (dense), entry k of the neuron adds its product to local output k, for k < 16. The stored index and `base_i` have no effect in this mode.
- R6: When entries applied in the same cycle target the same output, all of their products are added to it, and none is lost.
- R7: When `acc_clr_i` is 1 at a rising edge, all accumulators read 0 after that edge. Any update due on that edge is discarded.
- R8: `rd_data_o` shows, without a clock edge, the 24-bit two's-complement accumulator selected by `rd_addr_i`.
- R9: While `evt_ready_o` is 1, no accumulator changes except through a clear. Weight-memory and pointer writes never alter accumulators.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_i | input | 1 | 0 sparse (indexed) layout, 1 dense layout |
| base_i | input | 8 | Global index of this element's local output 0 |
| evt_valid_i | input | 1 | Event present |
| evt_ready_o | output | 1 | Element can accept an event |
| evt_val_i | input | 8 | Signed activation value |
| evt_addr_i | input | 4 | Input neuron address |
| wr_en_i | input | 1 | Weight memory write strobe |
| wr_addr_i | input | 6 | Weight memory entry address |
| wr_wgt_i | input | 8 | Signed weight |
| wr_idx_i | input | 8 | Global output index of the weight |
| ptr_en_i | input | 1 | Pointer table write strobe |
| ptr_addr_i | input | 4 | Input neuron whose pointer is written |
| ptr_start_i | input | 6 | First weight entry of that neuron |
| ptr_cnt_i | input | 7 | Number of weight entries of that neuron |
| acc_clr_i | input | 1 | Synchronous clear of all accumulators |
| rd_addr_i | input | 4 | Local output selected for readout |
| rd_data_o | output | 24 | Selected accumulator, signed |

## Verification
An event is accepted on one rising edge. Its final accumulator update lands on the edge that ends its last busy cycle, which is the same edge after which `evt_ready_o` rises again. The bench drives and samples only at falling edges. It counts how many falling edges see ready low after acceptance and compares that count with max(1, ceil(count/4)). It reads the accumulators only at the first falling edge where ready is high again. Readout is combinational, so each read settles 1 ns after `rd_addr_i` changes, with no extra cycle. A clear shows up at the falling edge after the edge that sampled it.

// File: rtl/sfc_pkg.sv
`timescale 1ns/1ps
package sfc_pkg;
  typedef enum logic {ST_IDLE = 1'b0, ST_BUSY = 1'b1} seq_state_e;
  typedef enum logic {MODE_SPARSE = 1'b0, MODE_DENSE = 1'b1} pe_mode_e;
endpackage

// File: rtl/sfc_wmem.sv
`timescale 1ns/1ps
module sfc_wmem #(
  parameter int WGT_W  = 8,
  parameter int GIDX_W = 8,
  parameter int DEPTH  = 64,
  parameter int N_IN   = 16,
  parameter int LANES  = 4,
  parameter int MEM_AW = 6,
  parameter int IN_AW  = 4,
  parameter int CNT_W  = 7
) (
  input  logic                              clk_i,
  input  logic                              rst_ni,
  input  logic                              w_we_i,
  input  logic [MEM_AW-1:0]                 w_addr_i,
  input  logic [WGT_W-1:0]                  w_wgt_i,
  input  logic [GIDX_W-1:0]                 w_idx_i,
  input  logic                              p_we_i,
  input  logic [IN_AW-1:0]                  p_addr_i,
  input  logic [MEM_AW-1:0]                 p_start_i,
  input  logic [CNT_W-1:0]                  p_cnt_i,
  input  logic [IN_AW-1:0]                  p_raddr_i,
  output logic [MEM_AW-1:0]                 p_rstart_o,
  output logic [CNT_W-1:0]                  p_rcnt_o,
  input  logic [LANES-1:0][MEM_AW-1:0]      l_addr_i,
  output logic [LANES-1:0][WGT_W-1:0]       l_wgt_o,
  output logic [LANES-1:0][GIDX_W-1:0]      l_idx_o
);
  logic [WGT_W-1:0]  wgt_mem [DEPTH];
  logic [GIDX_W-1:0] idx_mem [DEPTH];
  logic [MEM_AW-1:0] ps_q [N_IN];
  logic [CNT_W-1:0]  pc_q [N_IN];

  always_ff @(posedge clk_i) begin
    if (w_we_i) begin
      wgt_mem[w_addr_i] <= w_wgt_i;
      idx_mem[w_addr_i] <= w_idx_i;
    end
  end

  // counts reset to zero so unloaded neurons apply nothing
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < N_IN; i++) begin
        ps_q[i] <= '0;
        pc_q[i] <= '0;
      end
    end else if (p_we_i) begin
      ps_q[p_addr_i] <= p_start_i;
      pc_q[p_addr_i] <= p_cnt_i;
    end
  end

  assign p_rstart_o = ps_q[p_raddr_i];
  assign p_rcnt_o   = pc_q[p_raddr_i];

  for (genvar g = 0; g < LANES; g++) begin : g_rd
    assign l_wgt_o[g] = wgt_mem[l_addr_i[g]];
    assign l_idx_o[g] = idx_mem[l_addr_i[g]];
  end
endmodule

// File: rtl/sfc_seq.sv
`timescale 1ns/1ps
module sfc_seq #(
  parameter int LANES  = 4,
  parameter int VAL_W  = 8,
  parameter int MEM_AW = 6,
  parameter int CNT_W  = 7,
  parameter int OFF_W  = 8
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          evt_valid_i,
  input  logic [VAL_W-1:0]              evt_val_i,
  output logic                          evt_ready_o,
  input  logic [MEM_AW-1:0]             p_start_i,
  input  logic [CNT_W-1:0]              p_cnt_i,
  output logic [VAL_W-1:0]              val_o,
  output logic [LANES-1:0][MEM_AW-1:0]  l_addr_o,
  output logic [LANES-1:0]              l_en_o,
  output logic [LANES-1:0][OFF_W-1:0]   l_pos_o
);
  import sfc_pkg::*;

  seq_state_e        state_q;
  logic [VAL_W-1:0]  val_q;
  logic [MEM_AW-1:0] start_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [OFF_W-1:0]  off_q;
  logic [OFF_W-1:0]  off_nxt;

  assign off_nxt = off_q + OFF_W'(LANES);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      val_q   <= '0;
      start_q <= '0;
      cnt_q   <= '0;
      off_q   <= '0;
    end else begin
      case (state_q)
        ST_IDLE: begin
          if (evt_valid_i) begin
            val_q   <= evt_val_i;
            start_q <= p_start_i;
            cnt_q   <= p_cnt_i;
            off_q   <= '0;
            state_q <= ST_BUSY;
          end
        end
        ST_BUSY: begin
          off_q <= off_nxt;
          if (off_nxt >= {1'b0, cnt_q}) state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign evt_ready_o = (state_q == ST_IDLE);
  assign val_o       = val_q;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [OFF_W-1:0] pos;
    assign pos         = off_q + OFF_W'(g);
    assign l_pos_o[g]  = pos;
    assign l_en_o[g]   = (state_q == ST_BUSY) && (pos < {1'b0, cnt_q});
    assign l_addr_o[g] = start_q + pos[MEM_AW-1:0];
  end
endmodule

// File: rtl/sfc_scatter.sv
`timescale 1ns/1ps
module sfc_scatter #(
  parameter int LANES  = 4,
  parameter int N_OUT  = 16,
  parameter int VAL_W  = 8,
  parameter int WGT_W  = 8,
  parameter int ACC_W  = 24,
  parameter int GIDX_W = 8,
  parameter int OFF_W  = 8,
  parameter int OUT_AW = 4
) (
  input  logic                          mode_i,
  input  logic [GIDX_W-1:0]             base_i,
  input  logic [VAL_W-1:0]              val_i,
  input  logic [LANES-1:0]              l_en_i,
  input  logic [LANES-1:0][OFF_W-1:0]   l_pos_i,
  input  logic [LANES-1:0][WGT_W-1:0]   l_wgt_i,
  input  logic [LANES-1:0][GIDX_W-1:0]  l_idx_i,
  output logic [N_OUT-1:0][ACC_W-1:0]   upd_o
);
  import sfc_pkg::*;
  localparam int PROD_W = VAL_W + WGT_W;

  pe_mode_e mode;
  assign mode = pe_mode_e'(mode_i);

  logic [LANES-1:0]              hit;
  logic [LANES-1:0][OUT_AW-1:0]  tgt;
  logic [LANES-1:0][ACC_W-1:0]   ext;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic signed [PROD_W-1:0] prod;
    logic [GIDX_W:0]          rel;
    logic                     hit_sp;
    logic                     hit_dn;
    assign prod   = $signed(val_i) * $signed(l_wgt_i[g]);
    assign rel    = {1'b0, l_idx_i[g]} - {1'b0, base_i};
    assign hit_sp = !rel[GIDX_W] && (rel[GIDX_W-1:0] < GIDX_W'(N_OUT));
    assign hit_dn = l_pos_i[g] < OFF_W'(N_OUT);
    assign hit[g] = l_en_i[g] && ((mode == MODE_DENSE) ? hit_dn : hit_sp);
    assign tgt[g] = (mode == MODE_DENSE) ? l_pos_i[g][OUT_AW-1:0] : rel[OUT_AW-1:0];
    assign ext[g] = {{(ACC_W-PROD_W){prod[PROD_W-1]}}, prod};
  end

  // merge lanes per output so colliding targets both land
  always_comb begin
    for (int o = 0; o < N_OUT; o++) begin
      upd_o[o] = '0;
      for (int j = 0; j < LANES; j++) begin
        if (hit[j] && (tgt[j] == OUT_AW'(o))) upd_o[o] = upd_o[o] + ext[j];
      end
    end
  end
endmodule

// File: rtl/sfc_acc.sv
`timescale 1ns/1ps
module sfc_acc #(
  parameter int N_OUT  = 16,
  parameter int ACC_W  = 24,
  parameter int OUT_AW = 4
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         clr_i,
  input  logic [N_OUT-1:0][ACC_W-1:0]  upd_i,
  input  logic [OUT_AW-1:0]            rd_addr_i,
  output logic [ACC_W-1:0]             rd_data_o
);
  logic [N_OUT-1:0][ACC_W-1:0] acc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q <= '0;
    end else if (clr_i) begin
      acc_q <= '0;
    end else begin
      for (int o = 0; o < N_OUT; o++) acc_q[o] <= acc_q[o] + upd_i[o];
    end
  end

  assign rd_data_o = acc_q[rd_addr_i];
endmodule

// File: rtl/sfc_pe.sv
`timescale 1ns/1ps
module sfc_pe #(
  parameter int VAL_W  = 8,
  parameter int WGT_W  = 8,
  parameter int ACC_W  = 24,
  parameter int N_OUT  = 16,
  parameter int N_IN   = 16,
  parameter int DEPTH  = 64,
  parameter int LANES  = 4,
  parameter int GIDX_W = 8,
  localparam int MEM_AW = $clog2(DEPTH),
  localparam int IN_AW  = $clog2(N_IN),
  localparam int CNT_W  = $clog2(DEPTH + 1),
  localparam int OFF_W  = CNT_W + 1,
  localparam int OUT_AW = $clog2(N_OUT)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              mode_i,
  input  logic [GIDX_W-1:0] base_i,
  input  logic              evt_valid_i,
  output logic              evt_ready_o,
  input  logic [VAL_W-1:0]  evt_val_i,
  input  logic [IN_AW-1:0]  evt_addr_i,
  input  logic              wr_en_i,
  input  logic [MEM_AW-1:0] wr_addr_i,
  input  logic [WGT_W-1:0]  wr_wgt_i,
  input  logic [GIDX_W-1:0] wr_idx_i,
  input  logic              ptr_en_i,
  input  logic [IN_AW-1:0]  ptr_addr_i,
  input  logic [MEM_AW-1:0] ptr_start_i,
  input  logic [CNT_W-1:0]  ptr_cnt_i,
  input  logic              acc_clr_i,
  input  logic [OUT_AW-1:0] rd_addr_i,
  output logic [ACC_W-1:0]  rd_data_o
);
  logic [MEM_AW-1:0]                 p_start;
  logic [CNT_W-1:0]                  p_cnt;
  logic [VAL_W-1:0]                  cur_val;
  logic [LANES-1:0][MEM_AW-1:0]      l_addr;
  logic [LANES-1:0]                  l_en;
  logic [LANES-1:0][OFF_W-1:0]       l_pos;
  logic [LANES-1:0][WGT_W-1:0]       l_wgt;
  logic [LANES-1:0][GIDX_W-1:0]      l_idx;
  logic [N_OUT-1:0][ACC_W-1:0]       upd;

  sfc_wmem #(
    .WGT_W(WGT_W), .GIDX_W(GIDX_W), .DEPTH(DEPTH), .N_IN(N_IN), .LANES(LANES),
    .MEM_AW(MEM_AW), .IN_AW(IN_AW), .CNT_W(CNT_W)
  ) u_wmem (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .w_we_i(wr_en_i), .w_addr_i(wr_addr_i), .w_wgt_i(wr_wgt_i), .w_idx_i(wr_idx_i),
    .p_we_i(ptr_en_i), .p_addr_i(ptr_addr_i), .p_start_i(ptr_start_i), .p_cnt_i(ptr_cnt_i),
    .p_raddr_i(evt_addr_i), .p_rstart_o(p_start), .p_rcnt_o(p_cnt),
    .l_addr_i(l_addr), .l_wgt_o(l_wgt), .l_idx_o(l_idx)
  );

  sfc_seq #(
    .LANES(LANES), .VAL_W(VAL_W), .MEM_AW(MEM_AW), .CNT_W(CNT_W), .OFF_W(OFF_W)
  ) u_seq (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .evt_valid_i(evt_valid_i), .evt_val_i(evt_val_i), .evt_ready_o(evt_ready_o),
    .p_start_i(p_start), .p_cnt_i(p_cnt),
    .val_o(cur_val), .l_addr_o(l_addr), .l_en_o(l_en), .l_pos_o(l_pos)
  );

  sfc_scatter #(
    .LANES(LANES), .N_OUT(N_OUT), .VAL_W(VAL_W), .WGT_W(WGT_W), .ACC_W(ACC_W),
    .GIDX_W(GIDX_W), .OFF_W(OFF_W), .OUT_AW(OUT_AW)
  ) u_scatter (
    .mode_i(mode_i), .base_i(base_i), .val_i(cur_val),
    .l_en_i(l_en), .l_pos_i(l_pos), .l_wgt_i(l_wgt), .l_idx_i(l_idx),
    .upd_o(upd)
  );

  sfc_acc #(
    .N_OUT(N_OUT), .ACC_W(ACC_W), .OUT_AW(OUT_AW)
  ) u_acc (
    .clk_i(clk_i), .rst_ni(rst_ni), .clr_i(acc_clr_i), .upd_i(upd),
    .rd_addr_i(rd_addr_i), .rd_data_o(rd_data_o)
  );
endmodule

// File: rtl/sfc_pe_chk.sv
`timescale 1ns/1ps
module sfc_pe_chk #(
  parameter int ACC_W  = 24,
  parameter int OUT_AW = 4
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              evt_valid_i,
  input logic              evt_ready_o,
  input logic              acc_clr_i,
  input logic [OUT_AW-1:0] rd_addr_i,
  input logic [ACC_W-1:0]  rd_data_o
);
  // R2
  accept_stalls_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (evt_valid_i && evt_ready_o) |=> !evt_ready_o);

  // R2
  stall_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(evt_ready_o) |-> $past(evt_valid_i && evt_ready_o));

  // R7
  clear_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_clr_i |=> (rd_data_o == '0));

  // R9
  idle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (evt_ready_o && !acc_clr_i) |=> (!$stable(rd_addr_i) || $stable(rd_data_o)));

  // R8
  rd_known_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$isunknown(rd_data_o));
endmodule

bind sfc_pe sfc_pe_chk #(.ACC_W(ACC_W), .OUT_AW(OUT_AW)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .evt_valid_i(evt_valid_i), .evt_ready_o(evt_ready_o),
  .acc_clr_i(acc_clr_i), .rd_addr_i(rd_addr_i), .rd_data_o(rd_data_o)
);

// File: tb/sfc_pe_tb.sv
`timescale 1ns/1ps
module sfc_pe_tb;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        mode_i = 1'b0;
  logic [7:0]  base_i = '0;
  logic        evt_valid_i = 1'b0;
  logic        evt_ready_o;
  logic [7:0]  evt_val_i = '0;
  logic [3:0]  evt_addr_i = '0;
  logic        wr_en_i = 1'b0;
  logic [5:0]  wr_addr_i = '0;
  logic [7:0]  wr_wgt_i = '0;
  logic [7:0]  wr_idx_i = '0;
  logic        ptr_en_i = 1'b0;
  logic [3:0]  ptr_addr_i = '0;
  logic [5:0]  ptr_start_i = '0;
  logic [6:0]  ptr_cnt_i = '0;
  logic        acc_clr_i = 1'b0;
  logic [3:0]  rd_addr_i = '0;
  logic [23:0] rd_data_o;

  int total = 0;
  int fails = 0;
  bit done = 0;

  int m_w [64];
  int m_i [64];
  int m_ps [16];
  int m_pc [16];
  int m_acc [16];

  always #4 clk_i = ~clk_i;

  sfc_pe u_dut (.*);

  task automatic chk(input string req, input string what, input int act, input int exp);
    total++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic wr_w(input int a, input int w, input int ix);
    wr_en_i = 1'b1; wr_addr_i = 6'(a); wr_wgt_i = 8'(w); wr_idx_i = 8'(ix);
    m_w[a] = w; m_i[a] = ix;
    @(negedge clk_i);
    wr_en_i = 1'b0;
  endtask

  task automatic wr_p(input int n, input int s, input int c);
    ptr_en_i = 1'b1; ptr_addr_i = 4'(n); ptr_start_i = 6'(s); ptr_cnt_i = 7'(c);
    m_ps[n] = s; m_pc[n] = c;
    @(negedge clk_i);
    ptr_en_i = 1'b0;
  endtask

  // reference update from R3/R4/R5
  function automatic void model(input int v, input int n);
    for (int k = 0; k < m_pc[n]; k++) begin
      int e;
      int rel;
      e = (m_ps[n] + k) % 64;
      if (mode_i) begin
        if (k < 16) m_acc[k] += v * m_w[e];
      end else begin
        rel = m_i[e] - int'(base_i);
        if (rel >= 0 && rel < 16) m_acc[rel] += v * m_w[e];
      end
    end
  endfunction

  task automatic send(input string req, input int v, input int n);
    int beats;
    int c;
    while (!evt_ready_o) @(negedge clk_i);
    evt_valid_i = 1'b1; evt_val_i = 8'(v); evt_addr_i = 4'(n);
    @(negedge clk_i);
    evt_valid_i = 1'b0;
    beats = 0;
    while (!evt_ready_o && beats < 100) begin
      beats++;
      @(negedge clk_i);
    end
    c = m_pc[n];
    chk(req, "busy cycles", beats, (c == 0) ? 1 : (c + 3) / 4);
    model(v, n);
  endtask

  task automatic check_acc(input string req);
    for (int o = 0; o < 16; o++) begin
      rd_addr_i = 4'(o);
      #1;
      chk(req, $sformatf("acc[%0d]", o), int'($signed(rd_data_o)), m_acc[o]);
    end
    @(negedge clk_i);
  endtask

  task automatic t_reset;
    chk("R1", "ready after reset", int'(evt_ready_o), 1);
    check_acc("R1");
    // unloaded pointer has count 0: one busy cycle, no change
    send("R1", 9, 9);
    check_acc("R1");
  endtask

  task automatic t_sparse_basic;
    wr_w(0, 3, 0); wr_w(1, -2, 1); wr_w(2, 7, 2); wr_w(3, 1, 3);
    wr_p(1, 0, 4);
    check_acc("R9");
    send("R2", 100, 1);
    check_acc("R4");
  endtask

  task automatic t_multi_beat;
    for (int k = 0; k < 9; k++) wr_w(4 + k, (k % 2 == 0) ? (k + 1) : -(k + 1), 4 + k);
    wr_p(2, 4, 9);
    send("R2", -5, 2);
    check_acc("R3");
  endtask

  task automatic t_collide;
    wr_w(13, 10, 5); wr_w(14, 20, 5); wr_w(15, -3, 5); wr_w(16, 4, 14);
    wr_p(4, 13, 4);
    send("R6", 7, 4);
    check_acc("R6");
    // repoint neuron 1 onto two colliding entries
    wr_p(1, 13, 2);
    send("R3", 2, 1);
    check_acc("R3");
  endtask

  task automatic t_base;
    base_i = 8'd16;
    wr_w(17, 2, 16); wr_w(18, 3, 31); wr_w(19, 4, 5); wr_w(20, 5, 40);
    wr_p(5, 17, 4);
    send("R4", 11, 5);
    check_acc("R4");
    base_i = 8'd0;
  endtask

  task automatic t_dense;
    mode_i = 1'b1;
    base_i = 8'd99;
    for (int k = 0; k < 16; k++) wr_w(21 + k, k - 8, 200);
    wr_p(6, 21, 16);
    send("R5", 3, 6);
    check_acc("R5");
    mode_i = 1'b0;
    base_i = 8'd0;
  endtask

  task automatic t_wrap;
    // start 62 count 4 spans entries 62,63,0,1
    wr_w(62, 6, 9); wr_w(63, -4, 10);
    wr_p(7, 62, 4);
    send("R3", -9, 7);
    check_acc("R3");
  endtask

  task automatic t_clear;
    acc_clr_i = 1'b1;
    @(negedge clk_i);
    acc_clr_i = 1'b0;
    for (int o = 0; o < 16; o++) m_acc[o] = 0;
    check_acc("R7");
    send("R8", 1, 2);
    check_acc("R8");
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!done) begin
      total++; fails++;
      $display("FAIL R2 watchdog: actual=hung expected=finished");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 16; i++) begin m_ps[i] = 0; m_pc[i] = 0; m_acc[i] = 0; end
    for (int i = 0; i < 64; i++) begin m_w[i] = 0; m_i[i] = 0; end
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_reset();
    t_sparse_basic();
    t_multi_beat();
    t_collide();
    t_base();
    t_dense();
    t_wrap();
    t_clear();
    done = 1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule